// File: doc/BRIEF.md
# Hybrid Built-In Self-Test Sequencer

This block runs one self-test session on a combinational core. A start pulse begins the session. The block then drives a programmable number of patterns from a loadable linear-feedback shift register (LFSR). At a breakpoint set before the run, it switches to deterministic vectors fetched from a small synchronous pattern memory. These stored vectors exist to reach faults that random stimulus rarely excites. The block applies one pattern per clock and leaves no idle cycle at the hand-over.

Throughout both phases, every response returned by the core is folded into a single signature register. When the last pattern has been applied, the block pulses `done`. It compares the signature with an expected value supplied at its input and holds the resulting pass flag until the next session starts. Two corner cases are handled: a breakpoint of zero skips the random phase, and a vector count of zero ends the session after the random phase. The LFSR is built in one of two variants, chosen by a parameter: one that feeds the parity of the tapped bits back into bit 0, and one that applies the polynomial inside the shift path when the top bit is set.

Top module: `hbist_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `pat_valid` and `mem_rd` are all 0.
- R2: A `start` pulse in idle gives exactly one setup cycle, in which `busy`=1 and `pat_valid`=0, and then the patterns follow. `busy` stays 1 from that setup cycle through the `done` cycle. A `start` while busy changes nothing, and `done` is high for exactly one cycle.
- R3: The random phase applies exactly k (`cfg_prlen`) patterns. The first is the seed. With LFSR_TYPE=0, each next pattern is `{p[W-2:0], ^(p & poly)}`. With LFSR_TYPE=1, it is `{p[W-2:0],0} ^ (p[W-1] ? poly : 0)`.
- R4: An all-zero `cfg_seed` is replaced by the value 1, so the first random pattern is 1.
- R5: The deterministic phase applies M (`cfg_detcnt`) vectors, taken from addresses 0 to M-1 in order, with `pat_out` = `mem_data`. The memory returns data one cycle after `mem_rd`. `mem_rd` is high, with the right address, in the cycle before each vector is used.
- R6: `pat_valid` is high for exactly k+M consecutive cycles. `done` follows in the cycle after the last pattern, which is k+M+2 cycles after the `start` cycle.
- R7: With k=0 and M>0, the first stored vector is applied in the cycle right after setup.
- R8: With M=0, the session ends after the random phase and `mem_rd` is never raised. Over any session, `mem_rd` is raised exactly M times.
- R9: The signature is cleared in setup. On every pattern cycle it becomes `{s[W-2:0],0} ^ (s[W-1] ? MISR_POLY : 0) ^ rsp_in`. The default MISR_POLY is 16'h1021.
- R10: From the cycle after `done`, `pass` = (signature == `exp_sig`), and it holds until the next setup cycle clears it. With k=M=0, the signature is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session start request (used in idle only) |
| cfg_seed | input | PAT_W | LFSR seed |
| cfg_poly | input | PAT_W | LFSR feedback polynomial |
| cfg_prlen | input | CNT_W | Number of pseudo-random patterns k |
| cfg_detcnt | input | ADDR_W+1 | Number of stored vectors M |
| exp_sig | input | PAT_W | Expected final signature |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| pass | output | 1 | Signature matched expected value |
| pat_out | output | PAT_W | Pattern to the core under test |
| pat_valid | output | 1 | `pat_out` carries a pattern this cycle |
| rsp_in | input | PAT_W | Core response to the current pattern |
| mem_rd | output | 1 | Vector memory read strobe |
| mem_addr | output | ADDR_W | Vector memory read address |
| mem_data | input | PAT_W | Vector memory data, one cycle after read |

## Verification
Most internal faults in this block show up on `pat_out` in the very cycle they occur. A miscounted phase counter, a wrong LFSR step or a late memory address each yields a pattern that differs from the scoreboard's next expected item, a missing pattern, or a surplus one. A corrupted signature stays hidden until the cycle after `done`, where it appears only as a wrong `pass`. The bench therefore runs sessions with both matching and deliberately wrong expected signatures. An error in the phase-switch decision shows up as a `done` cycle that is off by one or more, or as a stray `mem_rd`.

// File: rtl/hbist_pkg.sv
package hbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_PRND = 3'd2,
    ST_DET  = 3'd3,
    ST_DONE = 3'd4
  } hb_state_e;

  localparam int unsigned LFSR_EXTERNAL = 0;
  localparam int unsigned LFSR_INTERNAL = 1;
endpackage

// File: rtl/hbist_lfsr.sv
module hbist_lfsr #(
  parameter int unsigned W    = 16,
  parameter int unsigned TYPE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] poly,
  input  logic         adv,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] state_q, state_d;
  logic [W-1:0] poly_q;
  logic [W-1:0] step;
  logic [W-1:0] seed_fix;

  assign seed_fix = (seed == '0) ? ONE : seed;

  generate
    if (TYPE == hbist_pkg::LFSR_EXTERNAL) begin : g_ext
      assign step = {state_q[W-2:0], ^(state_q & poly_q)};
    end else begin : g_int
      assign step = {state_q[W-2:0], 1'b0} ^ (state_q[W-1] ? poly_q : '0);
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (load)     state_d = seed_fix;
    else if (adv) state_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      poly_q  <= '0;
    end else begin
      if (load || adv) state_q <= state_d;
      if (load)        poly_q  <= poly;
    end
  end

  assign state = state_q;

  // R4: the register never steps from the all-zero state
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (state_q != '0));
  a_r4_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q != '0));
endmodule

// File: rtl/hbist_misr.sv
module hbist_misr #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic [W-1:0] sig_q, sig_d;

  always_comb begin
    sig_d = sig_q;
    if (clr)     sig_d = '0;
    else if (en) sig_d = ({sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0)) ^ din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sig_q <= '0;
    else if (clr || en) sig_q <= sig_d;
  end

  assign sig = sig_q;

  // R9: clearing wins and empties the signature
  a_r9_misr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig_q == '0));
  a_r9_misr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(sig_q));
endmodule

// File: rtl/hbist_seq.sv
module hbist_seq
  import hbist_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_prlen,
  input  logic [ADDR_W:0]   cfg_detcnt,
  output hb_state_e         state,
  output logic              lfsr_load,
  output logic              lfsr_adv,
  output logic              misr_clr,
  output logic              pat_act,
  output logic              det_sel,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done
);
  localparam int unsigned DC_W = ADDR_W + 1;

  hb_state_e         state_q, state_d;
  logic [CNT_W-1:0]  pr_left_q, pr_left_d;
  logic [DC_W-1:0]   det_left_q, det_left_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pr_zero, det_zero, pr_last, det_last;
  logic              cnt_en, addr_en;

  assign pr_zero  = (pr_left_q == '0);
  assign det_zero = (det_left_q == '0);
  assign pr_last  = (pr_left_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign det_last = (det_left_q == {{(DC_W-1){1'b0}}, 1'b1});

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_LOAD;
      ST_LOAD: begin
        if (!pr_zero)       state_d = ST_PRND;
        else if (!det_zero) state_d = ST_DET;
        else                state_d = ST_DONE;
      end
      ST_PRND: if (pr_last) state_d = det_zero ? ST_DONE : ST_DET;
      ST_DET:  if (det_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // counters and read address
  always_comb begin
    pr_left_d  = pr_left_q;
    det_left_d = det_left_q;
    addr_d     = addr_q;
    cnt_en     = 1'b0;
    addr_en    = 1'b0;
    if (state_q == ST_IDLE && start) begin
      pr_left_d  = cfg_prlen;
      det_left_d = cfg_detcnt;
      addr_d     = '0;
      cnt_en     = 1'b1;
      addr_en    = 1'b1;
    end else if (state_q == ST_PRND) begin
      pr_left_d = pr_left_q - 1'b1;
      cnt_en    = 1'b1;
    end else if (state_q == ST_DET) begin
      det_left_d = det_left_q - 1'b1;
      cnt_en     = 1'b1;
      if (!det_last) begin
        addr_d  = addr_q + 1'b1;
        addr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pr_left_q  <= '0;
      det_left_q <= '0;
      addr_q     <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        pr_left_q  <= pr_left_d;
        det_left_q <= det_left_d;
      end
      if (addr_en) addr_q <= addr_d;
    end
  end

  // memory reads are issued one cycle ahead of use
  always_comb begin
    mem_rd = 1'b0;
    unique case (state_q)
      ST_LOAD: mem_rd = pr_zero && !det_zero;
      ST_PRND: mem_rd = pr_last && !det_zero;
      ST_DET:  mem_rd = !det_last;
      default: mem_rd = 1'b0;
    endcase
  end

  assign mem_addr  = (state_q == ST_DET) ? (addr_q + 1'b1) : '0;
  assign state     = state_q;
  assign lfsr_load = (state_q == ST_IDLE) && start;
  assign lfsr_adv  = (state_q == ST_PRND);
  assign misr_clr  = (state_q == ST_LOAD);
  assign det_sel   = (state_q == ST_DET);
  assign pat_act   = (state_q == ST_PRND) || (state_q == ST_DET);
  assign done      = (state_q == ST_DONE);

  // R5: every stored vector was requested one cycle earlier
  a_r5_read_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DET) |-> $past(mem_rd));
  // R8: a read is always followed by a deterministic cycle
  a_r8_read_used: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (state_q == ST_DET));
  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: setup is reachable only from idle
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_LOAD));
  // R6: the random phase never ends early
  a_r6_prnd_stays: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PRND) && !pr_last) |=> (state_q == ST_PRND));
endmodule

// File: rtl/hbist_ctrl.sv
module hbist_ctrl
  import hbist_pkg::*;
#(
  parameter int unsigned      PAT_W     = 16,
  parameter int unsigned      CNT_W     = 16,
  parameter int unsigned      ADDR_W    = 6,
  parameter int unsigned      LFSR_TYPE = 0,
  parameter logic [PAT_W-1:0] MISR_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAT_W-1:0]  cfg_seed,
  input  logic [PAT_W-1:0]  cfg_poly,
  input  logic [CNT_W-1:0]  cfg_prlen,
  input  logic [ADDR_W:0]   cfg_detcnt,
  input  logic [PAT_W-1:0]  exp_sig,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [PAT_W-1:0]  pat_out,
  output logic              pat_valid,
  input  logic [PAT_W-1:0]  rsp_in,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [PAT_W-1:0]  mem_data
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  hb_state_e        state;
  logic             lfsr_load, lfsr_adv, misr_clr, pat_act, det_sel;
  logic [PAT_W-1:0] lfsr_state, sig;
  logic             pass_q, pass_d, pass_en;

  // reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  hbist_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start),
    .cfg_prlen  (cfg_prlen),
    .cfg_detcnt (cfg_detcnt),
    .state      (state),
    .lfsr_load  (lfsr_load),
    .lfsr_adv   (lfsr_adv),
    .misr_clr   (misr_clr),
    .pat_act    (pat_act),
    .det_sel    (det_sel),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .done       (done)
  );

  hbist_lfsr #(.W(PAT_W), .TYPE(LFSR_TYPE)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (lfsr_load),
    .seed  (cfg_seed),
    .poly  (cfg_poly),
    .adv   (lfsr_adv),
    .state (lfsr_state)
  );

  hbist_misr #(.W(PAT_W), .POLY(MISR_POLY)) u_misr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (misr_clr),
    .en    (pat_act),
    .din   (rsp_in),
    .sig   (sig)
  );

  assign pat_out   = det_sel ? mem_data : lfsr_state;
  assign pat_valid = pat_act;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    pass_d  = pass_q;
    pass_en = 1'b0;
    if (state == ST_LOAD) begin
      pass_d  = 1'b0;
      pass_en = 1'b1;
    end else if (state == ST_DONE) begin
      pass_d  = (sig == exp_sig);
      pass_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     pass_q <= 1'b0;
    else if (pass_en) pass_q <= pass_d;
  end
  assign pass = pass_q;

  // R6: patterns only while busy
  a_r6_valid_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    pat_valid |-> busy);
  // R10: result held while idle with no new start
  a_r10_pass_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((state == ST_IDLE) && !start) |=> $stable(pass));
  // R10: setup clears the previous result
  a_r10_pass_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_LOAD) |=> !pass);
endmodule

// File: tb/sim_hbist_ctrl.sv
module sim_hbist_ctrl;
  localparam int W  = 16;
  localparam int CW = 16;
  localparam int AW = 6;
  localparam logic [W-1:0] MP = 16'h1021;

  logic          clk, rst_n, start;
  logic [W-1:0]  cfg_seed, cfg_poly, exp_sig, rsp_in, mem_data, pat_out;
  logic [CW-1:0] cfg_prlen;
  logic [AW:0]   cfg_detcnt;
  logic          busy, done, pass, pat_valid, mem_rd;
  logic [AW-1:0] mem_addr;

  logic [W-1:0] mem [64];
  logic [W-1:0] exp_q [$];
  int errors = 0, checks = 0, rd_cnt = 0;

  hbist_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_seed(cfg_seed),
    .cfg_poly(cfg_poly), .cfg_prlen(cfg_prlen), .cfg_detcnt(cfg_detcnt),
    .exp_sig(exp_sig), .busy(busy), .done(done), .pass(pass),
    .pat_out(pat_out), .pat_valid(pat_valid), .rsp_in(rsp_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] core(input logic [W-1:0] p);
    return {p[7:0], p[15:8]} ^ 16'h5A5A ^ {p[14:0], 1'b0};
  endfunction
  assign rsp_in = core(pat_out);

  always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected pattern per valid cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) rd_cnt++;
      if (pat_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 extra pattern", pat_out, 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(pat_out == e, "R3/R5 pattern", pat_out, e);
        end
      end
    end
  end

  task automatic run(input logic [W-1:0] seed, input logic [W-1:0] poly,
                     input int k, input int m, input bit bad_sig, input bit poke,
                     input string tag);
    logic [W-1:0] s, sig;
    int n;
    s = (seed == '0) ? 16'h0001 : seed;
    sig = '0;
    for (int i = 0; i < k; i++) begin
      exp_q.push_back(s);
      sig = ({sig[14:0], 1'b0} ^ (sig[15] ? MP : '0)) ^ core(s);
      s = {s[14:0], ^(s & poly)};
    end
    for (int j = 0; j < m; j++) begin
      exp_q.push_back(mem[j]);
      sig = ({sig[14:0], 1'b0} ^ (sig[15] ? MP : '0)) ^ core(mem[j]);
    end
    rd_cnt = 0;
    cfg_seed = seed; cfg_poly = poly; cfg_prlen = CW'(k); cfg_detcnt = (AW+1)'(m);
    exp_sig = bad_sig ? (sig ^ 16'h0001) : sig;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(busy && !pat_valid, {"R2 setup ", tag}, {busy, pat_valid}, 2);
    while (!done && n < k + m + 20) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin
        start = 1'b1; cfg_prlen = 16'd2; cfg_seed = 16'h7777; cfg_detcnt = '0;
      end else start = 1'b0;
      if (!done) chk(busy, {"R2 busy ", tag}, busy, 1);
    end
    start = 1'b0;
    chk(n == k + m + 2, {"R6 done timing ", tag}, n, k + m + 2);
    chk(exp_q.size() == 0, {"R6 patterns left ", tag}, exp_q.size(), 0);
    chk(rd_cnt == m, {"R8 read count ", tag}, rd_cnt, m);
    exp_q.delete();
    @(negedge clk);
    chk(!done && !busy, {"R2 done pulse ", tag}, {done, busy}, 0);
    chk(pass == !bad_sig, {"R10 pass ", tag}, pass, !bad_sig);
    @(negedge clk);
    chk(pass == !bad_sig, {"R10 pass held ", tag}, pass, !bad_sig);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = W'(i * 16'h9E37) ^ 16'h1234;
    start = 0; cfg_seed = 16'hACE1; cfg_poly = 16'hB400;
    cfg_prlen = '0; cfg_detcnt = '0; exp_sig = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !pass && !pat_valid && !mem_rd, "R1 reset",
        {busy, done, pass, pat_valid, mem_rd}, 0);
    run(16'hACE1, 16'hB400, 20, 8, 0, 0, "base");          // R3 R5 R9 R10
    run(16'hACE1, 16'hB400, 20, 8, 1, 0, "bad signature"); // R10
    run(16'h0000, 16'hD008, 5, 3, 0, 0, "zero seed");      // R4
    run(16'h1357, 16'hB400, 0, 6, 0, 0, "k zero");         // R7
    run(16'h2468, 16'h8016, 12, 0, 0, 0, "m zero");        // R8
    run(16'h0F0F, 16'hB400, 0, 0, 0, 0, "empty");          // R10 signature 0
    run(16'h4321, 16'hB400, 10, 5, 0, 1, "start ignored"); // R2
    run(16'hBEEF, 16'hE100, 3, 64, 0, 0, "full memory");   // R5
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule